// File: doc/BRIEF.md
# Bridge Register Window with Access-Rights Enforcement

This block is the processor-facing register window of a bus bridge. It takes single-beat requests on a simple CPU bus and decodes the offset inside a 4 KB window. Each word slot in the register map is read/write, read-only, read-to-clear, write-only or reserved. The block checks every request against the rights and legal transfer sizes of the slot it hits. It then either performs the access or turns it into an error outcome. The registers have no function here beyond holding and returning data. The configuration window is a placeholder that accepts accesses and always reads as zero.

Error outcomes differ by cause. A reserved offset, an illegal transfer size, or a read of the write-only slot sets a sticky bus-error flag; a read in these cases also returns a fixed dummy word flagged with the data-error bit. A write to the read-only slot drops the data and raises no flag. Any burst request sets a sticky burst-error flag, and the non-maskable interrupt output follows that flag. Software clears each sticky flag with a write-one strobe.

Top module: `bridgeRegBlock`

## Requirements
- R1: Every request cycle (reqValid high) gives exactly one rspValid pulse on the next cycle, and rspValid is low in every other cycle. rspDataErr is always 0 for writes.
- R2: The read/write slots sit at offsets 0x00, 0x08, 0x14, 0x18, 0x20, 0x24, 0x28, 0x30, 0x40, 0x44, 0x50, 0x54 and 0x5C, and they reset to 0. A write updates only the byte lanes whose reqByteEn bit is set (bit n covers data bits 8n+7..8n). A read returns the full 32-bit word.
- R3: The legal byte-enable patterns are 4'b1111 (word), 4'b0011 or 4'b1100 (half-word), and any single bit (byte). Slots 0x1C, 0x24 and 0x58 accept only 4'b1111. An illegal pattern is handled like a reserved access (R4): busErr is set, nothing is written, and a read returns DUMMY_VAL with rspDataErr=1.
- R4: These offsets are reserved: 0x04, 0x0C, 0x2C, 0x34-0x3C, 0x48, 0x4C, 0x60-0xFC and 0x200-0xFFC. A read of a reserved offset sets busErr and returns DUMMY_VAL with rspDataErr=1. A write to a reserved offset sets busErr, and its data is lost.
- R5: Offset 0x10 is read-only and reads as VERSION_VAL. A write to it changes nothing and does not set busErr.
- R6: Offset 0x1C is a read-to-clear status word. A bit set by an rcSetIn pulse stays set until a legal read of 0x1C returns it, and that read clears the word. A bit set in the same cycle as the clearing read survives for the next read.
- R7: Offset 0x58 is write-only. A legal write to it gives one swResetPulse in the cycle of its response. A read of 0x58 is handled as a reserved read (R4).
- R8: A request with reqBurst=1 sets burstErr and changes no register. A burst read returns DUMMY_VAL with rspDataErr=1. A burst request does not set busErr.
- R9: busErr and burstErr stay set until errClear bit 0 or bit 1 (respectively) is pulsed. A set in the same cycle as a clear wins. nmi is high exactly while burstErr is set.
- R10: The configuration window 0x100-0x1FC accepts any legal size without error, reads as 0, and ignores writes.
- R11: Address bits [1:0] are ignored in decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset inside the window |
| reqByteEn | input | 4 | Byte-lane enables |
| reqBurst | input | 1 | Request is part of a burst |
| reqWdata | input | 32 | Write data |
| rcSetIn | input | 32 | Event bits ORed into the read-to-clear word |
| errClear | input | 2 | Write-one clear: bit 0 busErr, bit 1 burstErr |
| rspValid | output | 1 | Response valid, one cycle after request |
| rspRdata | output | 32 | Read data |
| rspDataErr | output | 1 | Read data flagged as erroneous |
| busErr | output | 1 | Sticky bus-error flag |
| burstErr | output | 1 | Sticky burst-error flag |
| nmi | output | 1 | Non-maskable interrupt request |
| swResetPulse | output | 1 | One-cycle strobe for a write to the write-only slot |

## Verification
The bench tries each of the five slot kinds with word, half-word and single-byte patterns. Partial writes to read/write slots show that the byte-lane merge puts each byte in the right place. The same half-word pattern is sent to a word-only slot and to an ordinary slot, which separates the size check from the reserved-offset decode. Burst, reserved, read-only and write-only reads are compared with each other: only some of them set busErr, some set burstErr, and only some of them return the flagged dummy word. The read-to-clear word is read with and without a coincident event, and the error flags are cleared with and without a coincident new error, so the bench checks that a set always wins over a clear.

// File: rtl/bregPkg.sv
package bregPkg;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int MAP_WORDS = 24;
  localparam int IDX_W     = $clog2(MAP_WORDS);

  typedef enum logic [2:0] {KIND_RSV, KIND_RW, KIND_RO, KIND_RC, KIND_WO} regKindT;
  typedef enum logic [2:0] {SEL_NONE, SEL_REG, SEL_VER, SEL_RC, SEL_ZERO, SEL_DUMMY} rdSelT;

  typedef struct packed {
    logic             valid;
    logic             doWrite;
    logic             clearRc;
    logic             pulseSw;
    logic             setBusErr;
    logic             setBurstErr;
    logic             respErr;
    rdSelT            rdSel;
    logic [IDX_W-1:0] idx;
    logic [BE_W-1:0]  be;
  } strobeT;

  function automatic regKindT kindOf(input logic [IDX_W-1:0] i);
    case (i)
      5'd0, 5'd2, 5'd5, 5'd6, 5'd8, 5'd9, 5'd10, 5'd12,
      5'd16, 5'd17, 5'd20, 5'd21, 5'd23: kindOf = KIND_RW;
      5'd4:    kindOf = KIND_RO;
      5'd7:    kindOf = KIND_RC;
      5'd22:   kindOf = KIND_WO;
      default: kindOf = KIND_RSV;
    endcase
  endfunction

  function automatic logic wordOnly(input logic [IDX_W-1:0] i);
    wordOnly = (i == 5'd7) || (i == 5'd9) || (i == 5'd22);
  endfunction
endpackage

// File: rtl/bregCtrl.sv
module bregCtrl
  import bregPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              reqBurst,
  output strobeT            strb
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic [IDX_W-1:0]  idxLo;
  logic              inMap;
  logic              inCfg;
  logic              sizeLegal;
  logic              fullWord;
  regKindT           kind;
  logic              bad;

  assign wordIdx   = reqAddr[ADDR_W-1:2];
  assign idxLo     = wordIdx[IDX_W-1:0];
  assign inMap     = wordIdx < WIDX_W'(MAP_WORDS);
  assign inCfg     = reqAddr[ADDR_W-1:8] == (ADDR_W-8)'(1);
  assign fullWord  = reqByteEn == 4'b1111;
  assign sizeLegal = fullWord || (reqByteEn == 4'b0011) ||
                     (reqByteEn == 4'b1100) || $onehot(reqByteEn);
  assign kind      = inMap ? kindOf(idxLo) : KIND_RSV;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    strb.idx   = idxLo;
    strb.be    = reqByteEn;
    strb.valid = reqValid;
    bad        = 1'b0;
    if (reqValid) begin
      if (reqBurst) begin
        strb.setBurstErr = 1'b1;
        if (!reqWrite) begin
          strb.rdSel   = SEL_DUMMY;
          strb.respErr = 1'b1;
        end
      end else if (inCfg) begin
        if (!sizeLegal) bad = 1'b1;
        else if (!reqWrite) strb.rdSel = SEL_ZERO;
      end else begin
        bad = !sizeLegal || (inMap && wordOnly(idxLo) && !fullWord) ||
              (kind == KIND_RSV) || (kind == KIND_WO && !reqWrite);
        if (!bad) begin
          case (kind)
            KIND_RW: begin
              if (reqWrite) strb.doWrite = 1'b1;
              else          strb.rdSel   = SEL_REG;
            end
            KIND_RO: if (!reqWrite) strb.rdSel = SEL_VER;
            KIND_RC: if (!reqWrite) begin
              strb.rdSel   = SEL_RC;
              strb.clearRc = 1'b1;
            end
            KIND_WO: strb.pulseSw = reqWrite;
            default: ;
          endcase
        end
      end
      if (bad) begin
        strb.setBusErr = 1'b1;
        if (!reqWrite) begin
          strb.rdSel   = SEL_DUMMY;
          strb.respErr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bregData.sv
module bregData
  import bregPkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0000_0102,
  parameter logic [DATA_W-1:0] DUMMY_VAL   = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rcSetIn,
  input  logic [1:0]        errClear,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDataErr,
  output logic              busErr,
  output logic              burstErr,
  output logic              swResetPulse
);
  localparam int SLOTS = 2 ** IDX_W;

  logic [DATA_W-1:0] regFile [SLOTS];
  logic [DATA_W-1:0] rcWord;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) regFile[i] <= '0;
    end else if (strb.doWrite) begin
      for (int i = 0; i < MAP_WORDS; i++) begin
        if (kindOf(IDX_W'(i)) == KIND_RW && strb.idx == IDX_W'(i)) begin
          for (int b = 0; b < BE_W; b++) begin
            if (strb.be[b]) regFile[i][8*b +: 8] <= reqWdata[8*b +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_REG:   rdNext = regFile[strb.idx];
      SEL_VER:   rdNext = VERSION_VAL;
      SEL_RC:    rdNext = rcWord;
      SEL_DUMMY: rdNext = DUMMY_VAL;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcWord       <= '0;
      busErr       <= 1'b0;
      burstErr     <= 1'b0;
      rspValid     <= 1'b0;
      rspRdata     <= '0;
      rspDataErr   <= 1'b0;
      swResetPulse <= 1'b0;
    end else begin
      rcWord       <= (strb.clearRc ? '0 : rcWord) | rcSetIn;
      busErr       <= (busErr & ~errClear[0]) | strb.setBusErr;
      burstErr     <= (burstErr & ~errClear[1]) | strb.setBurstErr;
      rspValid     <= strb.valid;
      rspRdata     <= rdNext;
      rspDataErr   <= strb.respErr;
      swResetPulse <= strb.pulseSw;
    end
  end
endmodule

// File: rtl/bridgeRegBlock.sv
module bridgeRegBlock
  import bregPkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [31:0] VERSION_VAL = 32'h0000_0102,
  parameter logic [31:0] DUMMY_VAL   = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqByteEn,
  input  logic              reqBurst,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       rcSetIn,
  input  logic [1:0]        errClear,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspDataErr,
  output logic              busErr,
  output logic              burstErr,
  output logic              nmi,
  output logic              swResetPulse
);
  strobeT strb;

  bregCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqByteEn(reqByteEn),
    .reqBurst (reqBurst),
    .strb     (strb)
  );

  bregData #(.VERSION_VAL(VERSION_VAL), .DUMMY_VAL(DUMMY_VAL)) data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWdata    (reqWdata),
    .rcSetIn     (rcSetIn),
    .errClear    (errClear),
    .rspValid    (rspValid),
    .rspRdata    (rspRdata),
    .rspDataErr  (rspDataErr),
    .busErr      (busErr),
    .burstErr    (burstErr),
    .swResetPulse(swResetPulse)
  );

  assign nmi = burstErr;
endmodule

// File: rtl/bregChk.sv
module bregChk #(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] DUMMY_VAL = 32'hDEAD_BEEF
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqBurst,
  input logic [1:0]        errClear,
  input logic              rspValid,
  input logic [31:0]       rspRdata,
  input logic              rspDataErr,
  input logic              busErr,
  input logic              burstErr,
  input logic              nmi,
  input logic              swResetPulse
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R1
  write_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite |=> !rspDataErr);

  // R4
  high_rsv_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && !reqBurst && (reqAddr[ADDR_W-1:9] != '0)
    |=> rspDataErr && rspRdata == DUMMY_VAL && busErr);

  // R8
  burst_nmi_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqBurst |=> nmi && burstErr);

  // R9
  bus_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr && !errClear[0] |=> busErr);

  // R9
  burst_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstErr && !errClear[1] |=> burstErr);

  // R7
  sw_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> $past(reqValid && reqWrite && !reqBurst));
endmodule

bind bridgeRegBlock bregChk #(.ADDR_W(ADDR_W), .DUMMY_VAL(DUMMY_VAL)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .reqBurst    (reqBurst),
  .errClear    (errClear),
  .rspValid    (rspValid),
  .rspRdata    (rspRdata),
  .rspDataErr  (rspDataErr),
  .busErr      (busErr),
  .burstErr    (burstErr),
  .nmi         (nmi),
  .swResetPulse(swResetPulse)
);

// File: tb/bridgeRegBlock_test.sv
module bridgeRegBlock_test;
  localparam logic [31:0] VER = 32'h0000_0102;
  localparam logic [31:0] DUM = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [3:0]  reqByteEn = '0;
  logic [31:0] reqWdata = '0, rcSetIn = '0;
  logic [1:0]  errClear = '0;
  logic        rspValid, rspDataErr, busErr, burstErr, nmi, swResetPulse;
  logic [31:0] rspRdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bridgeRegBlock uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqBurst(reqBurst),
    .reqWdata(reqWdata), .rcSetIn(rcSetIn), .errClear(errClear),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspDataErr(rspDataErr),
    .busErr(busErr), .burstErr(burstErr), .nmi(nmi), .swResetPulse(swResetPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [3:0] be,
                        input logic bst, input logic [31:0] wd, input logic [31:0] rcs,
                        input logic [1:0] ec, output logic [31:0] rd, output logic er,
                        output logic pl);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqByteEn = be;
    reqBurst = bst; reqWdata = wd; rcSetIn = rcs; errClear = ec;
    @(negedge clk);
    check("R1 rspValid", {31'd0, rspValid}, 32'd1);
    rd = rspRdata; er = rspDataErr; pl = swResetPulse;
    reqValid = 1'b0; reqBurst = 1'b0; rcSetIn = '0; errClear = '0;
    @(negedge clk);
    check("R1 single pulse", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic wrW(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] rd; logic er, pl;
    access(1'b1, a, be, 1'b0, d, '0, 2'b00, rd, er, pl);
    check("R1 write no data err", {31'd0, er}, 32'd0);
  endtask

  task automatic rdW(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d,
                     output logic er);
    logic pl;
    access(1'b0, a, be, 1'b0, '0, '0, 2'b00, d, er, pl);
  endtask

  task automatic clearErr();
    @(negedge clk); errClear = 2'b11;
    @(negedge clk); errClear = 2'b00;
    @(negedge clk);
    check("R9 flags cleared", {30'd0, busErr, burstErr}, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] d; logic er;
    check("R1 reset rspValid", {31'd0, rspValid}, 32'd0);
    check("R9 reset flags", {29'd0, busErr, burstErr, nmi}, 32'd0);
    rdW(12'h000, 4'hF, d, er);
    check("R2 reset value", d, 32'd0);
  endtask

  task automatic testReadWrite();
    logic [31:0] d; logic er;
    wrW(12'h000, 4'hF, 32'hA5A5_1234);
    rdW(12'h000, 4'hF, d, er);
    check("R2 word write", d, 32'hA5A5_1234);
    wrW(12'h008, 4'hF, 32'h1122_3344);
    wrW(12'h008, 4'b0010, 32'h0000_AB00);
    rdW(12'h008, 4'hF, d, er);
    check("R2 byte lane 1", d, 32'h1122_AB44);
    wrW(12'h05C, 4'b1100, 32'hBEEF_0000);
    rdW(12'h05C, 4'hF, d, er);
    check("R2 upper half", d, 32'hBEEF_0000);
    rdW(12'h00A, 4'hF, d, er);
    check("R11 low addr bits ignored", d, 32'h1122_AB44);
    check("R2 no bus error", {31'd0, busErr}, 32'd0);
  endtask

  task automatic testReadOnly();
    logic [31:0] d; logic er;
    rdW(12'h010, 4'hF, d, er);
    check("R5 version", d, VER);
    wrW(12'h010, 4'hF, 32'h1234_5678);
    check("R5 no error on write", {31'd0, busErr}, 32'd0);
    rdW(12'h010, 4'hF, d, er);
    check("R5 unchanged", d, VER);
  endtask

  task automatic testReserved();
    logic [31:0] d; logic er;
    rdW(12'h004, 4'hF, d, er);
    check("R4 dummy data", d, DUM);
    check("R4 data err", {31'd0, er}, 32'd1);
    check("R4 busErr on read", {31'd0, busErr}, 32'd1);
    clearErr();
    wrW(12'h02C, 4'hF, 32'h5555_5555);
    check("R4 busErr on write", {31'd0, busErr}, 32'd1);
    clearErr();
    rdW(12'h080, 4'hF, d, er);
    check("R4 gap above map", {er, busErr, 30'd0}, {2'b11, 30'd0});
    clearErr();
  endtask

  task automatic testSize();
    logic [31:0] d; logic er;
    wrW(12'h024, 4'hF, 32'hCAFE_0001);
    wrW(12'h024, 4'b0011, 32'h0000_FFFF);
    check("R3 half on word-only busErr", {31'd0, busErr}, 32'd1);
    clearErr();
    rdW(12'h024, 4'hF, d, er);
    check("R3 word-only unchanged", d, 32'hCAFE_0001);
    wrW(12'h014, 4'b0011, 32'h0000_FFFF);
    check("R3 half on normal slot ok", {31'd0, busErr}, 32'd0);
    wrW(12'h000, 4'b0110, 32'hFFFF_FFFF);
    check("R3 illegal pattern busErr", {31'd0, busErr}, 32'd1);
    clearErr();
    rdW(12'h000, 4'hF, d, er);
    check("R3 illegal pattern no write", d, 32'hA5A5_1234);
    rdW(12'h01C, 4'b0001, d, er);
    check("R3 byte read word-only", {er, 31'd0} | (d ^ DUM), {1'b1, 31'd0});
    clearErr();
  endtask

  task automatic testReadClear();
    logic [31:0] d; logic er, pl;
    @(negedge clk); rcSetIn = 32'h5;
    @(negedge clk); rcSetIn = '0;
    rdW(12'h01C, 4'hF, d, er);
    check("R6 read returns", d, 32'h5);
    rdW(12'h01C, 4'hF, d, er);
    check("R6 cleared by read", d, 32'h0);
    @(negedge clk); rcSetIn = 32'h3;
    @(negedge clk); rcSetIn = '0;
    access(1'b0, 12'h01C, 4'hF, 1'b0, '0, 32'h8, 2'b00, d, er, pl);
    check("R6 old value on coincident set", d, 32'h3);
    rdW(12'h01C, 4'hF, d, er);
    check("R6 coincident set survives", d, 32'h8);
  endtask

  task automatic testWriteOnly();
    logic [31:0] d; logic er, pl;
    access(1'b1, 12'h058, 4'hF, 1'b0, 32'h1, '0, 2'b00, d, er, pl);
    check("R7 write pulse", {31'd0, pl}, 32'd1);
    check("R7 pulse single", {31'd0, swResetPulse}, 32'd0);
    rdW(12'h058, 4'hF, d, er);
    check("R7 read dummy", d, DUM);
    check("R7 read flagged", {30'd0, er, busErr}, 32'd3);
    clearErr();
  endtask

  task automatic testBurst();
    logic [31:0] d; logic er, pl;
    access(1'b1, 12'h000, 4'hF, 1'b1, 32'h0BAD_0BAD, '0, 2'b00, d, er, pl);
    check("R8 burst flag and nmi", {30'd0, burstErr, nmi}, 32'd3);
    check("R8 busErr untouched", {31'd0, busErr}, 32'd0);
    access(1'b0, 12'h000, 4'hF, 1'b1, '0, '0, 2'b00, d, er, pl);
    check("R8 burst read dummy", d, DUM);
    check("R8 burst read flagged", {31'd0, er}, 32'd1);
    rdW(12'h000, 4'hF, d, er);
    check("R8 no register change", d, 32'hA5A5_1234);
    clearErr();
    check("R9 nmi follows burstErr", {31'd0, nmi}, 32'd0);
  endtask

  task automatic testClearRace();
    logic [31:0] d; logic er, pl;
    access(1'b0, 12'h004, 4'hF, 1'b0, '0, '0, 2'b01, d, er, pl);
    check("R9 set wins over clear", {31'd0, busErr}, 32'd1);
    clearErr();
  endtask

  task automatic testConfig();
    logic [31:0] d; logic er;
    wrW(12'h140, 4'hF, 32'h7777_7777);
    check("R10 write no error", {31'd0, busErr}, 32'd0);
    rdW(12'h140, 4'b0001, d, er);
    check("R10 reads zero", d, 32'd0);
    check("R10 no data err", {30'd0, er, busErr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadWrite();
    testReadOnly();
    testReserved();
    testSize();
    testReadClear();
    testWriteOnly();
    testBurst();
    testClearRace();
    testConfig();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule